// File: doc/BRIEF.md
# Core-local timer and interrupt unit

This unit keeps the time base of one processor core and raises its timer and software interrupt levels. A 64-bit time counter advances by one on every clock. Two compare registers are checked against it: a machine compare, reached through a 32-bit memory-mapped load/store port, and a supervisor compare, written by the core's CSR logic through a dedicated write port. A single machine software-interrupt bit is also mapped on the load/store port.

On a 32-bit core the supervisor compare is written in two halves, each with its own enable. On a 64-bit core (parameter `XLEN` = 64) the low enable writes the whole register. Both compare registers reset to all-ones, so nothing is pending after reset, and software silences a timer by writing all-ones back to its compare. The three pending levels leave the block as an 8-bit vector in the positions the core's pending register expects.

Top module: `ctmr_core`

## Requirements
- R1: After reset the time counter is 0, both compare registers and the supervisor compare output `scmp_o` are all-ones, the software bit is 0 and `irq_pend` is 0.
- R2: With no bus write, the time counter increases by one every clock and wraps from all-ones to zero.
- R3: A bus write to byte address BASE+0xBFF8 (low word) or BASE+0xBFFC (high word) loads that half of the time counter and holds the other half; there is no increment in that cycle.
- R4: The machine compare is written as a low word at BASE+0x4000 and a high word at BASE+0x4004, each independently; `irq_pend[7]` is 1 exactly when time >= machine compare (unsigned, 64 bits).
- R5: A bus write to BASE+0x0000 stores bit 0 of the write data as the software bit and discards the other bits; `irq_pend[3]` equals the software bit.
- R6: With `XLEN` = 32, `csr_wr_lo` loads `csr_wdata` into bits 31:0 and `csr_wr_hi` into bits 63:32 of the supervisor compare; both may fire together; without an enable the register holds. `scmp_o` shows the register.
- R7: `irq_pend[5]` is 1 exactly when time >= supervisor compare (unsigned, 64 bits), using the same time counter as R4.
- R8: Writing all-ones into both halves of a compare register clears its pending bit unless the time counter is itself all-ones.
- R9: A read (`bus_req`=1, `bus_we`=0) returns on `bus_rdata` in the next cycle the addressed word as it stood in the request cycle: software bit zero-extended, compare words, time words; otherwise `bus_rdata` is 0.
- R10: Accesses to any other address (unmapped offsets, byte-misaligned addresses, addresses outside the 64 KiB window at BASE) read 0 and writes to them change nothing.
- R11: Bits 0, 1, 2, 4 and 6 of `irq_pend` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Load/store request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after a read request |
| csr_wr_lo | input | 1 | Supervisor compare low-half (or full, 64-bit) write enable |
| csr_wr_hi | input | 1 | Supervisor compare high-half write enable |
| csr_wdata | input | XLEN | CSR write data |
| scmp_o | output | 64 | Supervisor compare value |
| irq_pend | output | 8 | Pending levels: bit 3 software, bit 5 supervisor timer, bit 7 machine timer |

## Verification
Every write, from the bus or the CSR port, lands on the clock edge that ends its request cycle, so the pending vector and `scmp_o` are sampled at the falling edge of that same cycle; read data is due one full cycle after the request and is sampled at the falling edge of the following cycle. The bench keeps its own model of the time counter, the compares and the software bit, advanced at every rising edge, and each read pushes the model's value at the request cycle into a queue that a monitor pops when the data is due. Pending checks compare the full 8-bit vector against the model, so the fixed zero bits are covered with every check.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
    localparam int TW = 64;          // time and compare width
    localparam int BW = 32;          // load/store data width
    localparam int WIN = 16;         // address bits inside the window

    localparam logic [WIN-1:0] OFS_SWI     = 16'h0000;
    localparam logic [WIN-1:0] OFS_MCMP_LO = 16'h4000;
    localparam logic [WIN-1:0] OFS_MCMP_HI = 16'h4004;
    localparam logic [WIN-1:0] OFS_TIME_LO = 16'hBFF8;
    localparam logic [WIN-1:0] OFS_TIME_HI = 16'hBFFC;

    localparam int PEND_W    = 8;
    localparam int PEND_SWI  = 3;
    localparam int PEND_STMR = 5;
    localparam int PEND_MTMR = 7;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SWI,
        SEL_MCMP_LO,
        SEL_MCMP_HI,
        SEL_TIME_LO,
        SEL_TIME_HI
    } sel_e;
endpackage

// File: rtl/ctmr_decode.sv
module ctmr_decode
    import ctmr_pkg::*;
#(
    parameter logic [31:0] BASE = 32'h0200_0000
) (
    input  logic [31:0] addr,
    output sel_e        sel
);
    logic in_win;
    assign in_win = (addr[31:WIN] == BASE[31:WIN]);

    always_comb begin
        sel = SEL_NONE;
        if (in_win) begin
            case (addr[WIN-1:0])
                OFS_SWI:     sel = SEL_SWI;
                OFS_MCMP_LO: sel = SEL_MCMP_LO;
                OFS_MCMP_HI: sel = SEL_MCMP_HI;
                OFS_TIME_LO: sel = SEL_TIME_LO;
                OFS_TIME_HI: sel = SEL_TIME_HI;
                default:     sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ctmr_cmp.sv
module ctmr_cmp #(
    parameter int W = 64
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] lim,
    output logic         ge
);
    // unsigned: counter has reached or passed the limit
    assign ge = (cnt >= lim);
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
    import ctmr_pkg::*;
#(
    parameter int          XLEN      = 32,             // 32 or 64
    parameter logic [31:0] BASE_ADDR = 32'h0200_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [31:0]       bus_addr,
    input  logic [BW-1:0]     bus_wdata,
    output logic [BW-1:0]     bus_rdata,
    input  logic              csr_wr_lo,
    input  logic              csr_wr_hi,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [TW-1:0]     scmp_o,
    output logic [PEND_W-1:0] irq_pend
);
    localparam int HW   = TW / 2;
    localparam int NCMP = 2;         // 0: machine, 1: supervisor

    typedef struct packed {
        logic [TW-1:0] tm;
        logic [TW-1:0] mcmp;
        logic [TW-1:0] scmp;
        logic          swi;
        logic [BW-1:0] rdata;
    } st_t;

    st_t  st_d, st_q;
    sel_e sel;
    logic wr_en, rd_en;
    logic [TW-1:0]   scmp_nx;
    logic [TW-1:0]   lim [NCMP];
    logic [NCMP-1:0] tmr_ge;
    logic [TW-1:0]   time_cur;

    assign wr_en = bus_req & bus_we;
    assign rd_en = bus_req & ~bus_we;

    ctmr_decode #(.BASE(BASE_ADDR)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    // supervisor compare write path: split halves or one full word
    generate
        if (XLEN == 32) begin : g_split
            always_comb begin
                scmp_nx = st_q.scmp;
                if (csr_wr_lo) scmp_nx[HW-1:0]  = csr_wdata[HW-1:0];
                if (csr_wr_hi) scmp_nx[TW-1:HW] = csr_wdata[HW-1:0];
            end
        end else begin : g_full
            always_comb begin
                scmp_nx = st_q.scmp;
                if (csr_wr_lo) scmp_nx = csr_wdata[TW-1:0];
            end
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.tm    = st_q.tm + {{(TW-1){1'b0}}, 1'b1};
        st_d.scmp  = scmp_nx;
        st_d.rdata = '0;

        if (wr_en) begin
            case (sel)
                SEL_SWI:     st_d.swi          = bus_wdata[0];
                SEL_MCMP_LO: st_d.mcmp[HW-1:0]  = bus_wdata;
                SEL_MCMP_HI: st_d.mcmp[TW-1:HW] = bus_wdata;
                SEL_TIME_LO: st_d.tm = {st_q.tm[TW-1:HW], bus_wdata};
                SEL_TIME_HI: st_d.tm = {bus_wdata, st_q.tm[HW-1:0]};
                default: ;
            endcase
        end

        if (rd_en) begin
            case (sel)
                SEL_SWI:     st_d.rdata = {{(BW-1){1'b0}}, st_q.swi};
                SEL_MCMP_LO: st_d.rdata = st_q.mcmp[HW-1:0];
                SEL_MCMP_HI: st_d.rdata = st_q.mcmp[TW-1:HW];
                SEL_TIME_LO: st_d.rdata = st_q.tm[HW-1:0];
                SEL_TIME_HI: st_d.rdata = st_q.tm[TW-1:HW];
                default:     st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{tm: '0, mcmp: '1, scmp: '1, swi: 1'b0, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lim[0] = st_q.mcmp;
    assign lim[1] = st_q.scmp;

    generate
        for (genvar i = 0; i < NCMP; i++) begin : g_cmp
            ctmr_cmp #(.W(TW)) u_cmp (
                .cnt (st_q.tm),
                .lim (lim[i]),
                .ge  (tmr_ge[i])
            );
        end
    endgenerate

    always_comb begin
        irq_pend            = '0;
        irq_pend[PEND_SWI]  = st_q.swi;
        irq_pend[PEND_STMR] = tmr_ge[1];
        irq_pend[PEND_MTMR] = tmr_ge[0];
    end

    assign bus_rdata = st_q.rdata;
    assign scmp_o    = st_q.scmp;
    assign time_cur  = st_q.tm;
endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
    parameter int          XLEN = 32,
    parameter logic [31:0] BASE = 32'h0200_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_req,
    input logic        bus_we,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        csr_wr_lo,
    input logic        csr_wr_hi,
    input logic [63:0] scmp_o,
    input logic [7:0]  irq_pend,
    input logic [63:0] time_cur
);
    localparam logic [31:0] TIME_LO_ADDR = BASE + 32'h0000_BFF8;

    // R2: steady increment with wrap when the bus does not write
    a_r2_time_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_req && bus_we))
        |-> (time_cur == $past(time_cur) + 64'd1));

    // R3: low-word load replaces the low half and holds the high half
    a_r3_time_lo_load: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_req && bus_we && bus_addr == TIME_LO_ADDR))
        |-> (time_cur[31:0] == $past(bus_wdata) && time_cur[63:32] == $past(time_cur[63:32])));

    // R5: software pending bit only moves after a bus write
    a_r5_swi_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_req && bus_we))
        |-> (irq_pend[3] == $past(irq_pend[3])));

    // R6: supervisor compare holds without a CSR write enable
    a_r6_scmp_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(csr_wr_lo) && !$past(csr_wr_hi))
        |-> (scmp_o == $past(scmp_o)));

    generate
        if (XLEN == 32) begin : g_half
            // R6: high half holds without its own enable
            a_r6_hi_hold: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(csr_wr_hi))
                |-> (scmp_o[63:32] == $past(scmp_o[63:32])));
        end
    endgenerate

    // R8: an all-ones supervisor compare keeps its pending bit low
    a_r8_ones_quiet: assert property (@(posedge clk) disable iff (rst)
        (scmp_o == 64'hFFFF_FFFF_FFFF_FFFF && time_cur != 64'hFFFF_FFFF_FFFF_FFFF)
        |-> !irq_pend[5]);

    // R9: read data is zero unless a read was requested the cycle before
    a_r9_rdata_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_req && !bus_we))
        |-> (bus_rdata == 32'd0));
endmodule

bind ctmr_core ctmr_chk #(.XLEN(XLEN), .BASE(BASE_ADDR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .csr_wr_lo (csr_wr_lo),
    .csr_wr_hi (csr_wr_hi),
    .scmp_o    (scmp_o),
    .irq_pend  (irq_pend),
    .time_cur  (time_cur)
);

// File: tb/ctmr_core_test.sv
module ctmr_core_test;
    localparam logic [31:0] A_SWI     = 32'h0200_0000;
    localparam logic [31:0] A_MCMP_LO = 32'h0200_4000;
    localparam logic [31:0] A_MCMP_HI = 32'h0200_4004;
    localparam logic [31:0] A_TIME_LO = 32'h0200_BFF8;
    localparam logic [31:0] A_TIME_HI = 32'h0200_BFFC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        csr_wr_lo = 1'b0, csr_wr_hi = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [63:0] scmp_o;
    logic [7:0]  irq_pend;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ctmr_core uut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .csr_wr_lo(csr_wr_lo), .csr_wr_hi(csr_wr_hi), .csr_wdata(csr_wdata),
        .scmp_o(scmp_o), .irq_pend(irq_pend)
    );

    // reference model, advanced at every rising edge
    logic [63:0] m_time, m_mcmp, m_scmp;
    logic        m_swi;

    always @(posedge clk) begin
        if (rst) begin
            m_time <= '0; m_mcmp <= '1; m_scmp <= '1; m_swi <= 1'b0;
        end else begin
            m_time <= m_time + 64'd1;
            if (bus_req && bus_we) begin
                case (bus_addr)
                    A_SWI:     m_swi <= bus_wdata[0];
                    A_MCMP_LO: m_mcmp[31:0]  <= bus_wdata;
                    A_MCMP_HI: m_mcmp[63:32] <= bus_wdata;
                    A_TIME_LO: m_time <= {m_time[63:32], bus_wdata};
                    A_TIME_HI: m_time <= {bus_wdata, m_time[31:0]};
                    default: ;
                endcase
            end
            if (csr_wr_lo) m_scmp[31:0]  <= csr_wdata;
            if (csr_wr_hi) m_scmp[63:32] <= csr_wdata;
        end
    end

    function automatic logic [31:0] rd_expect(input logic [31:0] a);
        case (a)
            A_SWI:     return {31'd0, m_swi};
            A_MCMP_LO: return m_mcmp[31:0];
            A_MCMP_HI: return m_mcmp[63:32];
            A_TIME_LO: return m_time[31:0];
            A_TIME_HI: return m_time[63:32];
            default:   return 32'd0;
        endcase
    endfunction

    function automatic logic [7:0] pend_expect();
        return {m_time >= m_mcmp, 1'b0, m_time >= m_scmp, 1'b0, m_swi, 3'b000};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard for read data
    logic [31:0] exp_v[$];
    string       exp_t[$];
    logic        rd_flag = 1'b0;

    always @(posedge clk) rd_flag <= bus_req && !bus_we && !rst;

    always @(negedge clk) begin
        if (rd_flag) begin
            if (exp_v.size() == 0) begin
                chk("R9 unexpected read data", {32'd0, bus_rdata}, 64'd0);
            end else begin
                logic [31:0] v;
                string t;
                v = exp_v.pop_front();
                t = exp_t.pop_front();
                chk(t, {32'd0, bus_rdata}, {32'd0, v});
            end
        end
    end

    task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [31:0] a, input string tag);
        @(posedge clk); #1;
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_v.push_back(rd_expect(a));
        exp_t.push_back(tag);
        @(posedge clk); #1;
        bus_req = 1'b0;
    endtask

    task automatic csr_wr(input logic lo, input logic hi, input logic [31:0] d);
        @(posedge clk); #1;
        csr_wr_lo = lo; csr_wr_hi = hi; csr_wdata = d;
        @(posedge clk); #1;
        csr_wr_lo = 1'b0; csr_wr_hi = 1'b0;
    endtask

    task automatic chk_pend(input string tag);
        @(negedge clk);
        chk(tag, {56'd0, irq_pend}, {56'd0, pend_expect()});
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        chk("R1 irq_pend after reset", {56'd0, irq_pend}, 64'd0);
        chk("R1 scmp_o after reset", scmp_o, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_rd(A_MCMP_LO, "R1 machine compare low after reset");
        bus_rd(A_MCMP_HI, "R1 machine compare high after reset");
        bus_rd(A_SWI, "R1 software bit after reset");

        // R2 / R9 back-to-back time reads
        bus_rd(A_TIME_LO, "R2 time low first read");
        bus_rd(A_TIME_LO, "R2 time low second read");

        // R3 time load
        bus_wr(A_TIME_LO, 32'h0000_0100);
        bus_rd(A_TIME_LO, "R3 time low after load");
        bus_rd(A_TIME_HI, "R3 time high held");

        // R4 machine compare halves and pending
        bus_wr(A_MCMP_HI, 32'h0);
        chk_pend("R4 pending with high half cleared");
        bus_wr(A_MCMP_LO, 32'h0000_0180);
        chk_pend("R4 pending before compare reached");
        bus_rd(A_MCMP_LO, "R4 machine compare low readback");
        bus_rd(A_MCMP_HI, "R4 machine compare high readback");
        idle(140);
        chk_pend("R4 pending after compare reached");
        chk("R4 machine timer bit set", {63'd0, irq_pend[7]}, 64'd1);

        // R8 all-ones silences machine timer
        bus_wr(A_MCMP_LO, 32'hFFFF_FFFF);
        bus_wr(A_MCMP_HI, 32'hFFFF_FFFF);
        chk_pend("R8 machine timer cleared by all-ones");

        // R5 software bit
        bus_wr(A_SWI, 32'hFFFF_FFFE);
        chk_pend("R5 only bit 0 is stored");
        bus_rd(A_SWI, "R5 software readback zero");
        bus_wr(A_SWI, 32'h0000_0001);
        chk_pend("R5 software pending set");
        chk("R5 software bit 3", {63'd0, irq_pend[3]}, 64'd1);
        bus_rd(A_SWI, "R5 software readback one");
        bus_wr(A_SWI, 32'h0);
        chk_pend("R5 software pending cleared");

        // R6 / R7 supervisor compare
        csr_wr(1'b1, 1'b0, 32'h0000_0400);
        @(negedge clk);
        chk("R6 low half written", scmp_o, 64'hFFFF_FFFF_0000_0400);
        chk_pend("R7 no supervisor pending with high half ones");
        csr_wr(1'b0, 1'b1, 32'h0);
        @(negedge clk);
        chk("R6 high half written", scmp_o, 64'h0000_0000_0000_0400);
        chk_pend("R7 supervisor pending before compare");
        idle(0);
        idle(700);
        chk_pend("R7 supervisor pending after compare");
        chk("R7 supervisor bit 5", {63'd0, irq_pend[5]}, 64'd1);
        csr_wr(1'b1, 1'b1, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R6 both halves together", scmp_o, 64'hFFFF_FFFF_FFFF_FFFF);
        chk_pend("R8 supervisor timer cleared by all-ones");

        // R2 wrap and compare at top of range
        bus_wr(A_TIME_HI, 32'hFFFF_FFFF);
        bus_wr(A_TIME_LO, 32'hFFFF_FFFB);
        bus_rd(A_TIME_LO, "R2 time low near top");
        chk_pend("R8 pending at time all-ones region");
        idle(2);
        bus_rd(A_TIME_HI, "R2 time high after wrap");
        bus_rd(A_TIME_LO, "R2 time low after wrap");
        chk_pend("R11 unused pending bits zero");

        // R10 unmapped and out-of-window accesses
        bus_wr(A_MCMP_LO, 32'h0000_1234);
        bus_wr(32'h0200_4008, 32'h5555_5555);
        bus_rd(32'h0200_4008, "R10 unmapped read zero");
        bus_wr(32'h0300_4000, 32'hAAAA_AAAA);
        bus_wr(32'h0200_4001, 32'hBBBB_BBBB);
        bus_rd(A_MCMP_LO, "R10 compare low untouched");
        bus_rd(32'h0300_4000, "R10 out-of-window read zero");
        bus_wr(32'h0200_0004, 32'h1);
        chk_pend("R10 unmapped write leaves software bit");

        idle(3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule